// File: doc/BRIEF.md
# Latched Serial-to-Parallel Sink Driver

This block models a chainable serial-in, parallel-out driver for low-side switches, built as two independently clocked register stages inside one system clock domain. A serial bit stream enters a shift chain on each rising edge of a shift strobe. A second strobe copies the whole chain into a holding register. An active-low enable then gates the held word onto the drive outputs. A drive bit of 1 turns its switch on, so that it sinks current. A drive bit of 0 turns it off.

The chain holds 8 bits per chained device, and the number of devices is a parameter. The bit in the last chain position leaves on a cascade output, which feeds the serial input of a further device. Both strobes and the clear are level inputs. They are sampled on the system clock, and each strobe acts on its sampled rising edge. The drive outputs are registered.

Top module: `latched_sink_driver`

## Requirements
- R1: Each sampled rising edge of `shift_strobe` moves every chain bit k to position k+1 and loads `ser_in` into position 0. The chain is updated at the system clock edge where the strobe is first seen high.
- R2: Each sampled rising edge of `latch_strobe` copies the whole chain into the holding register. Without such an edge the holding register keeps its value.
- R3: While `chain_clr_n` is low, the chain is forced to all zeros. The holding register, and therefore the drive outputs, are not affected.
- R4: While `out_en_n` is high, every bit of `drive` is 0 from the next clock onward. The held word is retained and reappears once the enable returns low.
- R5: While `out_en_n` is low, `drive[k]` equals holding-register bit k, one clock after the holding register changes. A value of 1 means that switch is sinking.
- R6: `cascade_out` always equals the last chain position, bit 8*N_DEV-1.
- R7: The chain length is 8*N_DEV bits. The first of 8*N_DEV bits shifted in ends up at `drive[8*N_DEV-1]`, and the last one ends up at `drive[0]`.
- R8: A low `chain_clr_n` takes priority over a coincident shift edge, so the chain stays all zeros.
- R9: After `rst`, the chain, the holding register, `drive` and `cascade_out` are all 0.
- R10: When both strobes rise in the same cycle, the holding register captures the chain contents from before that shift.
- R11: A shift strobe held high for many cycles causes exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into chain position 0 |
| shift_strobe | input | 1 | Shift clock; acts on its rising edge |
| latch_strobe | input | 1 | Register clock; acts on its rising edge |
| chain_clr_n | input | 1 | Active-low clear of the shift chain only |
| out_en_n | input | 1 | Active-low output enable |
| drive | output | 8*N_DEV | Switch-on bits, 1 = sinking |
| cascade_out | output | 1 | Last chain bit, for chaining devices |

## Verification
Two pairs of functions can meet in the same cycle. The first pair is a shift edge and a latch edge. The second pair is a shift edge and a clear. The bench raises both strobes on the same falling clock edge and expects the drive outputs to show the word from before the shift. A second latch pulse must then reveal the shifted word. It also pulls the clear low in the same cycle as a shift rise with a 1 on the serial input. A later latch must then yield all zeros.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  parameter int unsigned BITS_PER_DEV = 8;

  function automatic int unsigned chain_len(input int unsigned n_dev);
    return n_dev * BITS_PER_DEV;
  endfunction
endpackage

// File: rtl/lsd_edge_det.sv
module lsd_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/lsd_shift_chain.sv
module lsd_shift_chain #(
  parameter int unsigned N_DEV = 2
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      ser_in,
  input  logic                                      step,
  input  logic                                      clr_n,
  output logic [lsd_pkg::chain_len(N_DEV)-1:0]      q,
  output logic                                      tail
);
  localparam int unsigned BPD = lsd_pkg::BITS_PER_DEV;
  localparam int unsigned W   = lsd_pkg::chain_len(N_DEV);

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    logic [BPD-1:0] seg_r;
    logic           seg_in;

    if (d == 0) begin : g_head
      assign seg_in = ser_in;
    end else begin : g_link
      assign seg_in = q[d*BPD-1];
    end

    always_ff @(posedge clk) begin
      if (rst || !clr_n) seg_r <= '0;
      else if (step)     seg_r <= {seg_r[BPD-2:0], seg_in};
    end

    assign q[d*BPD +: BPD] = seg_r;
  end

  assign tail = q[W-1];
endmodule

// File: rtl/lsd_hold_gate.sv
module lsd_hold_gate #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         oe_n,
  output logic [W-1:0] hold,
  output logic [W-1:0] drive
);
  always_ff @(posedge clk) begin
    if (rst)       hold <= '0;
    else if (load) hold <= d;
  end

  always_ff @(posedge clk) begin
    if (rst || oe_n) drive <= '0;
    else             drive <= hold;
  end
endmodule

// File: rtl/latched_sink_driver.sv
module latched_sink_driver #(
  parameter int unsigned N_DEV = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 ser_in,
  input  logic                                 shift_strobe,
  input  logic                                 latch_strobe,
  input  logic                                 chain_clr_n,
  input  logic                                 out_en_n,
  output logic [lsd_pkg::chain_len(N_DEV)-1:0] drive,
  output logic                                 cascade_out
);
  localparam int unsigned W = lsd_pkg::chain_len(N_DEV);

  logic         sh_rise;
  logic         st_rise;
  logic [W-1:0] chain_q;
  logic [W-1:0] hold_q;

  lsd_edge_det u_sh_edge (.clk(clk), .rst(rst), .lvl(shift_strobe), .rise(sh_rise));
  lsd_edge_det u_st_edge (.clk(clk), .rst(rst), .lvl(latch_strobe), .rise(st_rise));

  lsd_shift_chain #(.N_DEV(N_DEV)) u_chain (
    .clk(clk), .rst(rst), .ser_in(ser_in), .step(sh_rise),
    .clr_n(chain_clr_n), .q(chain_q), .tail(cascade_out)
  );

  lsd_hold_gate #(.W(W)) u_hold (
    .clk(clk), .rst(rst), .load(st_rise), .d(chain_q),
    .oe_n(out_en_n), .hold(hold_q), .drive(drive)
  );
endmodule

// File: rtl/latched_sink_driver_chk.sv
module latched_sink_driver_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         ser_in,
  input logic         clr_n,
  input logic         oe_n,
  input logic         sh_rise,
  input logic         st_rise,
  input logic [W-1:0] chain_q,
  input logic [W-1:0] hold_q,
  input logic [W-1:0] drive
);
  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_rise && clr_n) |=> (chain_q[0] == $past(ser_in)));
  // R3
  clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (chain_q == '0));
  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !st_rise |=> $stable(hold_q));
  // R10
  hold_capture_chk: assert property (@(posedge clk) disable iff (rst)
    st_rise |=> (hold_q == $past(chain_q)));
  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (drive == '0));
  // R5
  gate_on_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |=> (drive == $past(hold_q)));
endmodule

bind latched_sink_driver latched_sink_driver_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .ser_in(ser_in), .clr_n(chain_clr_n),
  .oe_n(out_en_n), .sh_rise(sh_rise), .st_rise(st_rise),
  .chain_q(chain_q), .hold_q(hold_q), .drive(drive)
);

// File: tb/latched_sink_driver_tb.sv
module latched_sink_driver_tb_top;
  localparam int unsigned N_DEV = 2;
  localparam int unsigned W = 8 * N_DEV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0, shift_strobe = 1'b0, latch_strobe = 1'b0;
  logic chain_clr_n = 1'b1, out_en_n = 1'b0;
  logic [W-1:0] drive;
  logic cascade_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  latched_sink_driver #(.N_DEV(N_DEV)) dut_i (
    .clk(clk), .rst(rst), .ser_in(ser_in), .shift_strobe(shift_strobe),
    .latch_strobe(latch_strobe), .chain_clr_n(chain_clr_n),
    .out_en_n(out_en_n), .drive(drive), .cascade_out(cascade_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic shift_bit(input logic b, input int high_cycles);
    ser_in = b;
    tick(3);
    shift_strobe = 1'b1;
    tick(high_cycles);
    shift_strobe = 1'b0;
    tick(5);
  endtask

  task automatic shift_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) shift_bit(w[i], 5);
  endtask

  task automatic latch_pulse();
    latch_strobe = 1'b1;
    tick(5);
    latch_strobe = 1'b0;
    tick(5);
  endtask

  task automatic t_reset();
    check("R9 drive after reset", drive, '0);
    check("R9 cascade after reset", {{(W-1){1'b0}}, cascade_out}, '0);
  endtask

  task automatic t_load_word();
    shift_word(16'hA5C3);
    check("R2 no load without latch edge", drive, '0);
    latch_pulse();
    check("R5 R7 drive shows latched word", drive, 16'hA5C3);
    check("R6 cascade is last bit", {{(W-1){1'b0}}, cascade_out}, 16'h0001);
  endtask

  task automatic t_long_strobe();
    shift_bit(1'b0, 20);
    latch_pulse();
    check("R11 R1 single shift per long strobe", drive, 16'h4B86);
    check("R6 cascade after shift", {{(W-1){1'b0}}, cascade_out}, '0);
  endtask

  task automatic t_enable();
    out_en_n = 1'b1;
    tick(3);
    check("R4 drive off while disabled", drive, '0);
    out_en_n = 1'b0;
    tick(3);
    check("R4 R5 held word returns", drive, 16'h4B86);
  endtask

  task automatic t_clear();
    shift_word(16'hFFFF);
    check("R6 cascade before clear", {{(W-1){1'b0}}, cascade_out}, 16'h0001);
    chain_clr_n = 1'b0;
    tick(3);
    chain_clr_n = 1'b1;
    tick(2);
    check("R3 hold unaffected by clear", drive, 16'h4B86);
    check("R3 cascade after clear", {{(W-1){1'b0}}, cascade_out}, '0);
    latch_pulse();
    check("R3 chain emptied by clear", drive, '0);
  endtask

  task automatic t_clear_vs_shift();
    shift_word(16'h8001);
    ser_in = 1'b1;
    tick(3);
    chain_clr_n = 1'b0;
    shift_strobe = 1'b1;
    tick(5);
    shift_strobe = 1'b0;
    chain_clr_n = 1'b1;
    tick(5);
    latch_pulse();
    check("R8 clear beats coincident shift", drive, '0);
  endtask

  task automatic t_coincident();
    shift_word(16'h1234);
    ser_in = 1'b1;
    tick(3);
    shift_strobe = 1'b1;
    latch_strobe = 1'b1;
    tick(5);
    shift_strobe = 1'b0;
    latch_strobe = 1'b0;
    tick(5);
    check("R10 latch takes pre-shift word", drive, 16'h1234);
    latch_pulse();
    check("R10 R1 shifted word on next latch", drive, 16'h2469);
  endtask

  task automatic t_far_end();
    shift_word(16'h8000);
    latch_pulse();
    check("R7 first bit at far end", drive, 16'h8000);
    check("R7 R6 cascade carries far bit", {{(W-1){1'b0}}, cascade_out}, 16'h0001);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_load_word();
    t_long_strobe();
    t_enable();
    t_clear();
    t_clear_vs_shift();
    t_coincident();
    t_far_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule